// File: doc/BRIEF.md
# Instruction Cycle Phase Sequencer

This block is the hardwired control sequencer of a small single-accumulator, one-address processor. It keeps two registers: a 2-bit phase code that says which part of the instruction cycle is running (fetch, indirect, execute or interrupt), and a step counter that walks through the micro-operation steps T1, T2 and T3 of that phase. In every cycle it decodes the phase, the step and the instruction fields into a vector of individual control lines. These lines gate register transfers between PC, MAR, MBR, IR and AC, strobe memory reads and writes, and trigger the PC increment and the accumulator add.

The surrounding datapath supplies the opcode and the indirect-address bit of the instruction, an interrupt request, a pulse that arms interrupts, and a ready line from memory. A step that touches memory waits for ready. While it waits, every control line stays low and the phase and step hold. When an interrupt is taken, its arming is dropped automatically, so the service routine is not entered again straight away.

Top module: `instr_cycle_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the phase to fetch (00) and the step to T1 (0) at the next edge and disarms interrupts. While `rst` is high, every `ctl` line is 0.
- R2: `phase` encodes fetch=00, indirect=01, execute=10, interrupt=11. `step` encodes T1=0, T2=1, T3=2 and never takes the value 3. The bit map of `ctl` is: 0 PC to MAR, 1 memory read into MBR, 2 PC increment, 3 MBR to IR, 4 IR address field to MAR, 5 MBR address field to IR address field, 6 PC to MBR, 7 save address to MAR, 8 routine address to PC, 9 MBR written to memory, 10 AC plus MBR into AC.
- R3: Fetch asserts bit 0 in T1, bits 1 and 2 together in T2, and bit 3 in T3.
- R4: When fetch T3 completes, the next phase is indirect if `ind_bit` is 1 in that cycle and execute otherwise, with the step back at T1.
- R5: Indirect asserts bit 4 in T1, bit 1 in T2 and bit 5 in T3, and is always followed by execute at T1.
- R6: Execute with `opcode` equal to ADD_OPC (default 4'h1) asserts bit 4 in T1, bit 1 in T2 and bit 10 in T3. Any other opcode completes execute in T1 with no control line asserted.
- R7: When execute completes, the next phase is interrupt if `irq_req` is 1 and interrupts are armed, and fetch otherwise.
- R8: Interrupt asserts bit 6 in T1, bits 7 and 8 in T2 and bit 9 in T3, and is always followed by fetch. A pulse on `irq_arm` arms interrupts. Entering the interrupt phase disarms them, and this clear takes priority over an `irq_arm` pulse in the same cycle.
- R9: In a memory step (a T2 with bit 1, or interrupt T3) with `mem_ready` at 0, every `ctl` line is 0 and `phase` and `step` hold.
- R10: No register is written and read in the same step. MBR, PC and MAR each have at most one side (writer or reader) active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode field of the current instruction |
| ind_bit | input | 1 | Indirect-address bit of the instruction word; sampled at the end of fetch T3 |
| irq_req | input | 1 | Interrupt request level |
| irq_arm | input | 1 | Pulse that arms interrupts |
| mem_ready | input | 1 | Memory has completed the current access |
| phase | output | 2 | Current phase code |
| step | output | 2 | Current step within the phase |
| ctl | output | 11 | Control lines, bit map in R2 |

## Verification
Some rules are checked on every cycle by properties: stepping stays in range, indirect always leads to execute and interrupt always leads to fetch, a stalled memory step keeps every line quiet and holds its position, the fetch read and the PC increment share one step, and no register has a writer and a reader active together. Other behaviour depends on history and only the bench scenarios can show it. This covers the choice between indirect and execute at the end of fetch, the choice to take an interrupt, the opcode-dependent length of execute, and the arming state, including the case where disarm on entry beats a simultaneous arm pulse. The bench's reference model tracks these and compares phase, step and all control lines on every clock.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int CTL_W = 11;
  localparam int STEP_W = 2;

  localparam int C_PC_MAR   = 0;
  localparam int C_MEM_RD   = 1;
  localparam int C_PC_INC   = 2;
  localparam int C_MBR_IR   = 3;
  localparam int C_IRA_MAR  = 4;
  localparam int C_MBRA_IRA = 5;
  localparam int C_PC_MBR   = 6;
  localparam int C_SAV_MAR  = 7;
  localparam int C_RTN_PC   = 8;
  localparam int C_MEM_WR   = 9;
  localparam int C_ACC_ADD  = 10;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;
endpackage

// File: rtl/isc_step_decode.sv
module isc_step_decode
  import isc_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] ADD_OPC = 1
) (
  input  phase_e                   phase,
  input  logic [STEP_W-1:0]        step,
  input  logic [OPC_W-1:0]         opcode,
  output logic [CTL_W-1:0]         ctl_raw,
  output logic                     last_step,
  output logic                     mem_step
);
  always_comb begin
    ctl_raw   = '0;
    last_step = 1'b0;
    unique case (phase)
      PH_FETCH: begin
        case (step)
          2'd0: ctl_raw[C_PC_MAR] = 1'b1;
          2'd1: begin
            ctl_raw[C_MEM_RD] = 1'b1;
            ctl_raw[C_PC_INC] = 1'b1;
          end
          default: begin
            ctl_raw[C_MBR_IR] = 1'b1;
            last_step = 1'b1;
          end
        endcase
      end
      PH_INDIR: begin
        case (step)
          2'd0: ctl_raw[C_IRA_MAR] = 1'b1;
          2'd1: ctl_raw[C_MEM_RD] = 1'b1;
          default: begin
            ctl_raw[C_MBRA_IRA] = 1'b1;
            last_step = 1'b1;
          end
        endcase
      end
      PH_EXEC: begin
        if (opcode == ADD_OPC) begin
          case (step)
            2'd0: ctl_raw[C_IRA_MAR] = 1'b1;
            2'd1: ctl_raw[C_MEM_RD] = 1'b1;
            default: begin
              ctl_raw[C_ACC_ADD] = 1'b1;
              last_step = 1'b1;
            end
          endcase
        end else begin
          last_step = 1'b1;
        end
      end
      default: begin
        case (step)
          2'd0: ctl_raw[C_PC_MBR] = 1'b1;
          2'd1: begin
            ctl_raw[C_SAV_MAR] = 1'b1;
            ctl_raw[C_RTN_PC]  = 1'b1;
          end
          default: begin
            ctl_raw[C_MEM_WR] = 1'b1;
            last_step = 1'b1;
          end
        endcase
      end
    endcase
    mem_step = ctl_raw[C_MEM_RD] | ctl_raw[C_MEM_WR];
  end
endmodule

// File: rtl/isc_phase_next.sv
module isc_phase_next
  import isc_pkg::*;
(
  input  phase_e phase,
  input  logic   ind_bit,
  input  logic   irq_take,
  output phase_e phase_nxt
);
  always_comb begin
    unique case (phase)
      PH_FETCH: phase_nxt = ind_bit ? PH_INDIR : PH_EXEC;
      PH_INDIR: phase_nxt = PH_EXEC;
      PH_EXEC:  phase_nxt = irq_take ? PH_INTR : PH_FETCH;
      default:  phase_nxt = PH_FETCH;
    endcase
  end
endmodule

// File: rtl/isc_irq_gate.sv
module isc_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_arm,
  input  logic irq_req,
  input  logic enter_intr,
  output logic irq_take
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)             armed_q <= 1'b0;
    else if (enter_intr) armed_q <= 1'b0;
    else if (irq_arm)    armed_q <= 1'b1;
  end

  assign irq_take = irq_req & armed_q;
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import isc_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] ADD_OPC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ind_bit,
  input  logic             irq_req,
  input  logic             irq_arm,
  input  logic             mem_ready,
  output logic [1:0]       phase,
  output logic [1:0]       step,
  output logic [10:0]      ctl
);
  localparam logic [STEP_W-1:0] STEP_T1 = '0;

  phase_e              phase_q, phase_nxt;
  logic [STEP_W-1:0]   step_q;
  logic [CTL_W-1:0]    ctl_raw;
  logic                last_step, mem_step, stall, irq_take, enter_intr;

  isc_step_decode #(.OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_dec (
    .phase(phase_q), .step(step_q), .opcode(opcode),
    .ctl_raw(ctl_raw), .last_step(last_step), .mem_step(mem_step)
  );

  isc_irq_gate u_irq (
    .clk(clk), .rst(rst), .irq_arm(irq_arm), .irq_req(irq_req),
    .enter_intr(enter_intr), .irq_take(irq_take)
  );

  isc_phase_next u_nxt (
    .phase(phase_q), .ind_bit(ind_bit), .irq_take(irq_take),
    .phase_nxt(phase_nxt)
  );

  assign stall      = mem_step & ~mem_ready;
  assign enter_intr = ~rst & ~stall & last_step & (phase_nxt == PH_INTR)
                      & (phase_q == PH_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      step_q  <= STEP_T1;
    end else if (!stall) begin
      if (last_step) begin
        phase_q <= phase_nxt;
        step_q  <= STEP_T1;
      end else begin
        step_q  <= step_q + 1'b1;
      end
    end
  end

  assign ctl   = (rst || stall) ? '0 : ctl_raw;
  assign phase = phase_q;
  assign step  = step_q;
endmodule

// File: rtl/isc_seq_checker.sv
module isc_seq_checker
  import isc_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] ADD_OPC = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             mem_ready,
  input logic [1:0]       phase,
  input logic [1:0]       step,
  input logic [10:0]      ctl
);
  logic is_mem;
  assign is_mem = (step == 2'd1 && phase != 2'b11 &&
                   (phase != 2'b10 || opcode == ADD_OPC)) ||
                  (step == 2'd2 && phase == 2'b11);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == 2'b00 && step == 2'd0));

  a_r2_step_range: assert property (@(posedge clk) disable iff (rst)
    step != 2'd3);

  a_r3_fetch_pair: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && step == 2'd1 && mem_ready) |-> (ctl[C_MEM_RD] && ctl[C_PC_INC]));

  a_r5_indir_to_exec: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b01 && step == 2'd2) |=> (phase == 2'b10 && step == 2'd0));

  a_r8_intr_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11 && step == 2'd2 && mem_ready) |=> (phase == 2'b00 && step == 2'd0));

  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    (is_mem && !mem_ready) |-> (ctl == '0));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (is_mem && !mem_ready) |=> ($stable(phase) && $stable(step)));

  a_r10_mbr_excl: assert property (@(posedge clk) disable iff (rst)
    !((ctl[C_MEM_RD] || ctl[C_PC_MBR]) &&
      (ctl[C_MBR_IR] || ctl[C_MBRA_IRA] || ctl[C_MEM_WR] || ctl[C_ACC_ADD])));

  a_r10_pc_excl: assert property (@(posedge clk) disable iff (rst)
    !((ctl[C_PC_INC] || ctl[C_RTN_PC]) && (ctl[C_PC_MAR] || ctl[C_PC_MBR])));

  a_r10_mar_excl: assert property (@(posedge clk) disable iff (rst)
    !((ctl[C_PC_MAR] || ctl[C_IRA_MAR] || ctl[C_SAV_MAR]) &&
      (ctl[C_MEM_RD] || ctl[C_MEM_WR])));
endmodule

bind instr_cycle_seq isc_seq_checker #(.OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .mem_ready(mem_ready),
  .phase(phase), .step(step), .ctl(ctl)
);

// File: tb/instr_cycle_seq_tb.sv
module instr_cycle_seq_tb_top;
  logic clk = 1'b0;
  logic rst, ind_bit, irq_req, irq_arm, mem_ready;
  logic [3:0] opcode;
  logic [1:0] phase, step;
  logic [10:0] ctl;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_ph = 0, m_st = 0, m_prev = -1;
  bit m_arm = 0, m_valid = 0;

  always #4 clk = ~clk;

  instr_cycle_seq dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .ind_bit(ind_bit),
    .irq_req(irq_req), .irq_arm(irq_arm), .mem_ready(mem_ready),
    .phase(phase), .step(step), .ctl(ctl)
  );

  function automatic logic [10:0] ref_lines(int ph, int st, logic [3:0] opc);
    logic [10:0] v = '0;
    if (ph == 0) begin
      if (st == 0) v[0] = 1; else if (st == 1) begin v[1] = 1; v[2] = 1; end else v[3] = 1;
    end else if (ph == 1) begin
      if (st == 0) v[4] = 1; else if (st == 1) v[1] = 1; else v[5] = 1;
    end else if (ph == 2) begin
      if (opc == 4'h1) begin
        if (st == 0) v[4] = 1; else if (st == 1) v[1] = 1; else v[10] = 1;
      end
    end else begin
      if (st == 0) v[6] = 1; else if (st == 1) begin v[7] = 1; v[8] = 1; end else v[9] = 1;
    end
    return v;
  endfunction

  function automatic bit ref_final(int ph, int st, logic [3:0] opc);
    if (ph == 2 && opc != 4'h1) return 1;
    return st == 2;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: compare at negedge+1, advance the model, wait to next negedge
  task automatic cyc(bit r, bit rdy, bit ind, bit irq, bit arm, logic [3:0] opc);
    logic [10:0] raw, exp;
    bit stl, fin;
    string tag;
    rst = r; mem_ready = rdy; ind_bit = ind; irq_req = irq; irq_arm = arm; opcode = opc;
    #1;
    raw = ref_lines(m_ph, m_st, opc);
    stl = (raw[1] || raw[9]) && !rdy;
    exp = (r || stl) ? 11'h0 : raw;
    tag = r ? "R1" : stl ? "R9" : (m_ph == 0) ? "R3" : (m_ph == 1) ? "R5" : (m_ph == 2) ? "R6" : "R8";
    check(ctl === exp, tag, "ctl", int'(ctl), int'(exp));
    check(!((ctl[1] || ctl[6]) && (ctl[3] || ctl[5] || ctl[9] || ctl[10])) &&
          !((ctl[2] || ctl[8]) && (ctl[0] || ctl[6])) &&
          !((ctl[0] || ctl[4] || ctl[7]) && (ctl[1] || ctl[9])),
          "R10", "register conflict in ctl", int'(ctl), 0);
    if (m_valid) begin
      tag = (m_prev == -1) ? "R1" : (m_prev == 0) ? "R4" : (m_prev == 1) ? "R5" :
            (m_prev == 2) ? "R7" : "R8";
      check(phase === 2'(m_ph), tag, "phase", int'(phase), m_ph);
      check(step === 2'(m_st), "R2", "step", int'(step), m_st);
    end
    // model update
    if (r) begin
      m_ph = 0; m_st = 0; m_arm = 0; m_valid = 1; m_prev = -1;
    end else begin
      fin = ref_final(m_ph, m_st, opc);
      if (!stl && fin) begin
        int nph;
        if (m_ph == 0) nph = ind ? 1 : 2;
        else if (m_ph == 1) nph = 2;
        else if (m_ph == 2) nph = (irq && m_arm) ? 3 : 0;
        else nph = 0;
        if (nph == 3) m_arm = 0;
        else if (arm) m_arm = 1;
        m_prev = m_ph; m_ph = nph; m_st = 0;
      end else begin
        if (arm) m_arm = 1;
        if (!stl) m_st = m_st + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n, bit rdy, bit ind, bit irq, bit arm, logic [3:0] opc);
    for (int i = 0; i < n; i++) cyc(0, rdy, ind, irq, arm, opc);
  endtask

  initial begin
    rst = 1; mem_ready = 1; ind_bit = 0; irq_req = 0; irq_arm = 0; opcode = 4'h1;
    @(negedge clk);
    // R1: reset state and quiet lines
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 4'h1);
    check(phase === 2'b00 && step === 2'd0, "R1", "reset phase/step", int'({phase, step}), 0);
    // R3/R4/R6: direct ADD instruction stream
    run(12, 1, 0, 0, 0, 4'h1);
    // R4/R5: indirect instruction
    run(18, 1, 1, 0, 0, 4'h1);
    // R6: non-ADD opcode executes in one step
    run(8, 1, 0, 0, 0, 4'h7);
    // R9: stalled memory read
    run(1, 1, 0, 0, 0, 4'h1);
    run(5, 0, 0, 0, 0, 4'h1);
    run(10, 1, 0, 0, 0, 4'h1);
    // R7/R8: armed interrupt taken once, then disarmed
    run(1, 1, 0, 0, 1, 4'h7);
    run(16, 1, 0, 1, 0, 4'h7);
    // R9: stall on the interrupt save write
    run(2, 1, 0, 1, 1, 4'h7);
    while (!(m_ph == 3 && m_st == 2)) cyc(0, 1, 0, 1, 0, 4'h7);
    run(4, 0, 0, 1, 0, 4'h7);
    run(12, 1, 0, 1, 0, 4'h7);
    // R8: arm pulse coinciding with interrupt entry is overridden by the clear
    run(1, 1, 0, 0, 1, 4'h7);
    while (!(m_ph == 2)) cyc(0, 1, 0, 1, 0, 4'h7);
    cyc(0, 1, 0, 1, 1, 4'h7);
    check(phase === 2'b11, "R8", "entered interrupt", int'(phase), 3);
    run(12, 1, 0, 1, 0, 4'h7);
    check(!(phase === 2'b11), "R8", "no re-entry after clear", int'(phase), 0);
    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      int u = $urandom;
      cyc((u % 97) == 0, (u >> 8) % 4 != 0, (u >> 12) % 2 == 1, (u >> 13) % 2 == 1,
          (u >> 14) % 8 == 0, ((u >> 17) % 3 == 0) ? 4'h5 : 4'h1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule